// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits between a converter's sample path and its output serializer. Each clock it produces one output word. That word is either the live converter sample or a substitute pattern that a downstream receiver can use to prove it captures data correctly. The substitute patterns are:

- a constant word with only the top bit set;
- words taken from four programmable user registers, either repeating one word or cycling through all four;
- a short pseudorandom stream from a 9-stage shift register;
- a long pseudorandom stream from a 23-stage shift register.

Both pseudorandom streams start from fixed non-standard seeds. The long one is bit-inverted. Each stream is cut into 12-bit words, earliest bit in the word MSB.

Words are left-aligned in a 14-bit output and trimmed to a selectable length of 8, 10, 12 or 14 bits. A companion output gives the number of valid bits. The pseudorandom modes always produce 12-bit words.

A small state machine tracks the active mode. It has eight states:

- `ST_PASS`: live sample.
- `ST_FIXED`: constant word.
- `ST_USR0`, `ST_USR1`, `ST_USR2`, `ST_USR3`: user word 0, 1, 2 or 3.
- `ST_PN_S`: short pseudorandom stream.
- `ST_PN_L`: long pseudorandom stream.

The state is chosen again on every clock, as follows:

- Mode pass or any reserved code goes to `ST_PASS`.
- Mode fixed goes to `ST_FIXED`.
- Mode short-PN goes to `ST_PN_S`. Mode long-PN goes to `ST_PN_L`.
- Mode user with alternation off goes to `ST_USR0`.
- Mode user with alternation on steps `ST_USR0`→`ST_USR1`→`ST_USR2`→`ST_USR3`→`ST_USR0`. From any non-user state it goes to `ST_USR0`.
- A transition into `ST_PN_S` or `ST_PN_L` from any other state reloads that generator's seed.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While `rst_n` is low, and until the first clock edge after its release, `pat_word` is 0 and `word_bits` is 12.
- R2: `mode_sel` encodes 0 = pass, 1 = fixed, 2 = user, 3 = short PN, 4 = long PN; codes 5 to 7 act as pass. Inputs sampled at a rising edge determine the word shown after that edge. In pass mode the word is `sample_in`, formatted as in R3.
- R3: `len_sel` encodes 0 = 12, 1 = 8, 2 = 10, 3 = 14 bits, and `word_bits` reports that length in every mode other than PN. The word occupies the top `word_bits` bits of `pat_word[13:0]` and all lower bits are 0. A 12-bit source (sample, fixed) is placed in bits [13:2] with bits [1:0] zero before trimming. User registers are 14 bits wide and are used as-is.
- R4: Fixed mode outputs the 12-bit word 0x800, which is 14'h2000 at length 12.
- R5: User mode with `alt_en` = 0 outputs `user_w0` on every word.
- R6: User mode with `alt_en` = 1 cycles `user_w0`, `user_w1`, `user_w2`, `user_w3`, then repeats. It starts at `user_w0` when entered from another mode. When `alt_en` rises while `user_w0` is shown, the next word is `user_w1`.
- R7: The short PN stream follows a(k) = a(k-9) XOR a(k-5) with seed 0x0DF. Its first three words are 0xDF9, 0x353 and 0x301, and the word sequence repeats after 511 words.
- R8: The long PN stream follows a(k) = a(k-23) XOR a(k-18) with seed 0x29B80A and inverted output bits. Its first three words are 0x591, 0xFD7 and 0x0A3.
- R9: In PN modes `len_sel` has no effect. `word_bits` is 12 and `pat_word` = {word, 2'b00}.
- R10: Each entry into a PN mode from any other state, including the other PN mode, restarts that stream at its first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one word per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Pattern mode select (R2) |
| len_sel | input | 2 | Word length select (R3) |
| alt_en | input | 1 | Cycle through the four user words |
| user_w0 | input | 14 | User word 0, left-aligned |
| user_w1 | input | 14 | User word 1, left-aligned |
| user_w2 | input | 14 | User word 2, left-aligned |
| user_w3 | input | 14 | User word 3, left-aligned |
| sample_in | input | 12 | Live converter sample |
| pat_word | output | 14 | Output word, left-aligned and trimmed |
| word_bits | output | 4 | Number of valid bits in `pat_word` |

## Verification
The hardest behaviour to reach from the ports is the short stream's wrap after 511 words. Reaching it means holding short-PN mode for more than 511 consecutive clocks without a mode change. The stimulus does exactly that: it runs 515 words back to back and checks the word after the wrap against the first word. The bench builds its expected bit stream from the stated recurrence as a flat bit array, not a shift register. Seed reloads are driven by hopping between fixed, short-PN and long-PN modes, including a direct switch between the two PN modes.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int WORD_W = 12;
    localparam int OUT_W  = 14;

    localparam logic [2:0] MODE_PASS  = 3'd0;
    localparam logic [2:0] MODE_FIXED = 3'd1;
    localparam logic [2:0] MODE_USER  = 3'd2;
    localparam logic [2:0] MODE_PN_S  = 3'd3;
    localparam logic [2:0] MODE_PN_L  = 3'd4;

    typedef enum logic [2:0] {
        ST_PASS,
        ST_FIXED,
        ST_USR0,
        ST_USR1,
        ST_USR2,
        ST_USR3,
        ST_PN_S,
        ST_PN_L
    } tpg_state_e;

    function automatic logic [3:0] len_bits(input logic [1:0] sel);
        logic [3:0] r;
        unique case (sel)
            2'd0:    r = 4'd12;
            2'd1:    r = 4'd8;
            2'd2:    r = 4'd10;
            default: r = 4'd14;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tpg_fsm.sv
module tpg_fsm
    import tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       alt_en,
    output tpg_state_e state_q,
    output tpg_state_e state_nxt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = ST_PASS;
        unique case (mode_sel)
            MODE_FIXED: state_nxt = ST_FIXED;
            MODE_PN_S:  state_nxt = ST_PN_S;
            MODE_PN_L:  state_nxt = ST_PN_L;
            MODE_USER: begin
                if (!alt_en) begin
                    state_nxt = ST_USR0;
                end else begin
                    unique case (state_q)
                        ST_USR0: state_nxt = ST_USR1;
                        ST_USR1: state_nxt = ST_USR2;
                        ST_USR2: state_nxt = ST_USR3;
                        default: state_nxt = ST_USR0;
                    endcase
                end
            end
            default:    state_nxt = ST_PASS;
        endcase
    end

    a_r6_alt_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_USER && alt_en && state_q == ST_USR3) |=> state_q == ST_USR0);

    a_r5_hold_user0: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_USER && !alt_en) |=> state_q == ST_USR0);

endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
    parameter int             LEN    = 9,
    parameter int             TAP    = 5,
    parameter logic [LEN-1:0] SEED   = 9'h0DF,
    parameter bit             INVERT = 1'b0,
    parameter int             WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    output logic [WORD_W-1:0] word
);

    logic [LEN-1:0] st_q;
    logic [LEN-1:0] adv;

    // Register holds the last LEN bits, oldest in the MSB; each step
    // appends a(k) = a(k-LEN) ^ a(k-TAP) and emits the new oldest bit.
    always_comb begin
        logic [LEN-1:0] s;
        s    = load ? SEED : st_q;
        word = '0;
        for (int i = 0; i < WORD_W; i++) begin
            s = {s[LEN-2:0], s[LEN-1] ^ s[TAP-1]};
            word[WORD_W-1-i] = s[LEN-1] ^ INVERT;
        end
        adv = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (run) begin
            st_q <= adv;
        end
    end

    a_r7_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |-> st_q != '0);

endmodule

// File: rtl/tpg_format.sv
module tpg_format
    import tpg_pkg::*;
#(
    parameter int OW = OUT_W,
    parameter int WW = WORD_W
) (
    input  logic [OW-1:0] src,
    input  logic          honour_len,
    input  logic [1:0]    len_sel,
    output logic [OW-1:0] word,
    output logic [3:0]    bits
);

    localparam logic [OW-1:0] ONES = '1;

    always_comb begin
        bits = honour_len ? len_bits(len_sel) : 4'(WW);
        word = src & ~(ONES >> bits);
    end

endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic [1:0]        len_sel,
    input  logic              alt_en,
    input  logic [OUT_W-1:0]  user_w0,
    input  logic [OUT_W-1:0]  user_w1,
    input  logic [OUT_W-1:0]  user_w2,
    input  logic [OUT_W-1:0]  user_w3,
    input  logic [WORD_W-1:0] sample_in,
    output logic [OUT_W-1:0]  pat_word,
    output logic [3:0]        word_bits
);

    localparam int PAD_W = OUT_W - WORD_W;
    localparam logic [WORD_W-1:0] FIXED_WORD = {1'b1, {(WORD_W-1){1'b0}}};

    tpg_state_e state_q;
    tpg_state_e state_nxt;

    logic [WORD_W-1:0] pn_s_word;
    logic [WORD_W-1:0] pn_l_word;
    logic              load_s;
    logic              load_l;
    logic              run_s;
    logic              run_l;
    logic [OUT_W-1:0]  src;
    logic              honour;
    logic [OUT_W-1:0]  fmt_word;
    logic [3:0]        fmt_bits;

    tpg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .alt_en    (alt_en),
        .state_q   (state_q),
        .state_nxt (state_nxt)
    );

    assign run_s  = (state_nxt == ST_PN_S);
    assign run_l  = (state_nxt == ST_PN_L);
    assign load_s = run_s && (state_q != ST_PN_S);
    assign load_l = run_l && (state_q != ST_PN_L);

    tpg_lfsr #(
        .LEN    (9),
        .TAP    (5),
        .SEED   (9'h0DF),
        .INVERT (1'b0),
        .WORD_W (WORD_W)
    ) u_pn_short (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_s),
        .run   (run_s),
        .word  (pn_s_word)
    );

    tpg_lfsr #(
        .LEN    (23),
        .TAP    (18),
        .SEED   (23'h29B80A),
        .INVERT (1'b1),
        .WORD_W (WORD_W)
    ) u_pn_long (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_l),
        .run   (run_l),
        .word  (pn_l_word)
    );

    always_comb begin
        honour = 1'b1;
        unique case (state_nxt)
            ST_FIXED: src = {FIXED_WORD, {PAD_W{1'b0}}};
            ST_USR0:  src = user_w0;
            ST_USR1:  src = user_w1;
            ST_USR2:  src = user_w2;
            ST_USR3:  src = user_w3;
            ST_PN_S: begin
                src    = {pn_s_word, {PAD_W{1'b0}}};
                honour = 1'b0;
            end
            ST_PN_L: begin
                src    = {pn_l_word, {PAD_W{1'b0}}};
                honour = 1'b0;
            end
            default:  src = {sample_in, {PAD_W{1'b0}}};
        endcase
    end

    tpg_format #(
        .OW (OUT_W),
        .WW (WORD_W)
    ) u_fmt (
        .src        (src),
        .honour_len (honour),
        .len_sel    (len_sel),
        .word       (fmt_word),
        .bits       (fmt_bits)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_word  <= '0;
            word_bits <= 4'd12;
        end else begin
            pat_word  <= fmt_word;
            word_bits <= fmt_bits;
        end
    end

    a_r7_short_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_nxt == ST_PN_S && state_q != ST_PN_S) |=> pat_word == {12'hDF9, {PAD_W{1'b0}}});

    a_r8_long_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_nxt == ST_PN_L && state_q != ST_PN_L) |=> pat_word == {12'h591, {PAD_W{1'b0}}});

    a_r9_pn_width: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PN_S || state_q == ST_PN_L) |-> word_bits == 4'(WORD_W));

    a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_word & ({OUT_W{1'b1}} >> word_bits)) == '0);

    a_r4_fixed_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_FIXED && len_sel == 2'd0) |=> pat_word == {FIXED_WORD, {PAD_W{1'b0}}});

endmodule

// File: tb/tb_adc_test_pattern_gen.sv
`timescale 1ns/1ps
module tb_adc_test_pattern_gen;

    logic        clk;
    logic        rst_n;
    logic [2:0]  mode_sel;
    logic [1:0]  len_sel;
    logic        alt_en;
    logic [13:0] user_w0, user_w1, user_w2, user_w3;
    logic [11:0] sample_in;
    logic [13:0] pat_word;
    logic [3:0]  word_bits;

    adc_test_pattern_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .len_sel   (len_sel),
        .alt_en    (alt_en),
        .user_w0   (user_w0),
        .user_w1   (user_w1),
        .user_w2   (user_w2),
        .user_w3   (user_w3),
        .sample_in (sample_in),
        .pat_word  (pat_word),
        .word_bits (word_bits)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;

    logic [13:0] q_w[$];
    logic [3:0]  q_b[$];
    string       q_t[$];

    bit sa [0:6399];
    bit la [0:799];

    function automatic int lenb(input logic [1:0] l);
        case (l)
            2'd0:    return 12;
            2'd1:    return 8;
            2'd2:    return 10;
            default: return 14;
        endcase
    endfunction

    function automatic logic [13:0] trim(input logic [13:0] v, input int bits);
        logic [13:0] m;
        m = 14'h3FFF;
        for (int i = 0; i < 14; i++) if (i < 14 - bits) m[i] = 1'b0;
        return v & m;
    endfunction

    task automatic build_pn();
        logic [8:0]  ss;
        logic [22:0] ls;
        ss = 9'h0DF;
        ls = 23'h29B80A;
        for (int i = 0; i < 9; i++) sa[i] = ss[8-i];
        for (int k = 9; k < 6400; k++) sa[k] = sa[k-9] ^ sa[k-5];
        for (int i = 0; i < 23; i++) la[i] = ls[22-i];
        for (int k = 23; k < 800; k++) la[k] = la[k-23] ^ la[k-18];
    endtask

    function automatic logic [11:0] short_w(input int j);
        logic [11:0] w;
        for (int b = 0; b < 12; b++) w[11-b] = sa[12*j+1+b];
        return w;
    endfunction

    function automatic logic [11:0] long_w(input int j);
        logic [11:0] w;
        for (int b = 0; b < 12; b++) w[11-b] = ~la[12*j+1+b];
        return w;
    endfunction

    // driver: applies one word's inputs and pushes the expected result
    task automatic drive(input logic [2:0] m, input logic [1:0] l, input logic a,
                         input logic [11:0] smp, input logic [13:0] src14,
                         input bit honour, input string tag);
        int bits;
        @(negedge clk);
        #1;
        mode_sel  = m;
        len_sel   = l;
        alt_en    = a;
        sample_in = smp;
        bits      = honour ? lenb(l) : 12;
        q_w.push_back(trim(src14, bits));
        q_b.push_back(4'(bits));
        q_t.push_back(tag);
    endtask

    // monitor: compares each produced word with the scoreboard head
    always @(negedge clk) begin
        if (q_w.size() > 0) begin
            logic [13:0] ew;
            logic [3:0]  eb;
            string       et;
            ew = q_w.pop_front();
            eb = q_b.pop_front();
            et = q_t.pop_front();
            checks++;
            if (pat_word !== ew || word_bits !== eb) begin
                errors++;
                $display("FAIL %s: pat_word=%h word_bits=%0d expected %h/%0d",
                         et, pat_word, word_bits, ew, eb);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [11:0] e;
        rst_n = 1'b0; mode_sel = 3'd1; len_sel = 2'd1; alt_en = 1'b0;
        sample_in = 12'hABC;
        user_w0 = 14'h3A5F; user_w1 = 14'h1234; user_w2 = 14'h2BCD; user_w3 = 14'h0777;
        build_pn();
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (pat_word !== 14'h0 || word_bits !== 4'd12) begin
            errors++;
            $display("FAIL R1: pat_word=%h word_bits=%0d expected 0000/12", pat_word, word_bits);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 pass and reserved codes
        drive(3'd0, 2'd0, 1'b0, 12'hABC, {12'hABC, 2'b00}, 1, "R2");
        drive(3'd0, 2'd1, 1'b0, 12'h5A3, {12'h5A3, 2'b00}, 1, "R2");
        drive(3'd6, 2'd3, 1'b0, 12'hFFF, {12'hFFF, 2'b00}, 1, "R2");
        drive(3'd7, 2'd2, 1'b0, 12'h0F1, {12'h0F1, 2'b00}, 1, "R2");

        // R3 lengths on a user word, R4 fixed word
        for (int l = 0; l < 4; l++) drive(3'd2, 2'(l), 1'b0, 12'h0, user_w0, 1, "R3");
        drive(3'd1, 2'd0, 1'b0, 12'h0, 14'h2000, 1, "R4");
        drive(3'd1, 2'd3, 1'b0, 12'h0, 14'h2000, 1, "R4");

        // R5 hold word 0
        for (int i = 0; i < 3; i++) drive(3'd2, 2'd3, 1'b0, 12'h0, user_w0, 1, "R5");
        // R6 alternation from hold: next is word 1
        drive(3'd2, 2'd3, 1'b1, 12'h0, user_w1, 1, "R6");
        drive(3'd2, 2'd3, 1'b1, 12'h0, user_w2, 1, "R6");
        drive(3'd2, 2'd3, 1'b1, 12'h0, user_w3, 1, "R6");
        drive(3'd2, 2'd3, 1'b1, 12'h0, user_w0, 1, "R6");
        drive(3'd2, 2'd3, 1'b1, 12'h0, user_w1, 1, "R6");
        drive(3'd2, 2'd3, 1'b0, 12'h0, user_w0, 1, "R5");
        // R6 entry from another mode starts at word 0
        drive(3'd1, 2'd3, 1'b1, 12'h0, 14'h2000, 1, "R4");
        drive(3'd2, 2'd3, 1'b1, 12'h0, user_w0, 1, "R6");
        drive(3'd2, 2'd3, 1'b1, 12'h0, user_w1, 1, "R6");

        // R7 short stream, including the wrap after 511 words
        drive(3'd1, 2'd0, 1'b0, 12'h0, 14'h2000, 1, "R4");
        for (int j = 0; j < 515; j++) begin
            if (j == 0 || j == 511) e = 12'hDF9;
            else if (j == 1)        e = 12'h353;
            else if (j == 2)        e = 12'h301;
            else                    e = short_w(j);
            drive(3'd3, 2'd0, 1'b0, 12'h0, {e, 2'b00}, 0, "R7");
        end

        // R8 long stream, R9 length ignored
        drive(3'd0, 2'd0, 1'b0, 12'h123, {12'h123, 2'b00}, 1, "R2");
        for (int j = 0; j < 40; j++) begin
            if (j == 0)      e = 12'h591;
            else if (j == 1) e = 12'hFD7;
            else if (j == 2) e = 12'h0A3;
            else             e = long_w(j);
            drive(3'd4, 2'(j % 4), 1'b0, 12'h0, {e, 2'b00}, 0, (j < 3) ? "R8" : "R9");
        end

        // R10 re-entry reloads the seed
        drive(3'd1, 2'd0, 1'b0, 12'h0, 14'h2000, 1, "R4");
        drive(3'd3, 2'd1, 1'b0, 12'h0, {12'hDF9, 2'b00}, 0, "R10");
        drive(3'd3, 2'd2, 1'b0, 12'h0, {12'h353, 2'b00}, 0, "R10");
        drive(3'd4, 2'd3, 1'b0, 12'h0, {12'h591, 2'b00}, 0, "R10");
        drive(3'd4, 2'd3, 1'b0, 12'h0, {12'hFD7, 2'b00}, 0, "R10");
        drive(3'd3, 2'd0, 1'b0, 12'h0, {12'hDF9, 2'b00}, 0, "R10");
        drive(3'd4, 2'd0, 1'b0, 12'h0, {12'h591, 2'b00}, 0, "R10");

        repeat (3) @(negedge clk);
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule